// File: doc/BRIEF.md
# Sequenced Chip Reset Controller

This block decides when the chip enters reset and when it comes out again. Four sources can request a reset: an external active-low reset pin, a watchdog expiry pulse, a software reset strobe, and a loss of PLL lock. A loss of lock counts only in PLL clock mode and only while its enable is set. The pin must be held low for several consecutive sampled clock edges before it counts as a request, so short glitches are filtered out. The pin and the lock input each pass through a two-flop synchronizer first.

When a request is accepted, the block records which sources caused it and raises a bus monitor enable. It then waits for the bus cycle in progress to finish, or for a bounded timeout, before it drives the chip-wide reset output. After that it moves through a fixed sequence: it waits for the pin to go high, then waits for PLL lock, then holds reset for a fixed count. It samples a configuration pin in the last cycle of reset. If the pin requalifies as asserted during the lock wait or the hold count, the sequence goes back to waiting for the pin to go high.

After power-up the block comes out of its own power-on reset with the reset output asserted, in the wait-for-pin-release step.

Top module: `rst_sequencer`

## Requirements
- R1: The pin counts as a request only after the synchronized pin has been low on QUAL_EDGES consecutive rising edges. A shorter low pulse causes no reset.
- R2: The watchdog pulse and the software strobe are reset sources. Loss of synchronized lock is a source only when `pll_mode` and `lol_rst_en` are both 1.
- R3: On an accepted request, `bus_mon_en` rises on the next cycle and `cause` captures the active sources. The bit layout is [0] pin, [1] watchdog, [2] software, [3] loss of lock, and several bits may be set at once.
- R4: `rst_out` rises on the cycle after `bus_done` is seen while `bus_mon_en` is high, and `bus_mon_en` falls on that same cycle. The two outputs are never high together.
- R5: If `bus_done` never arrives, `bus_mon_en` stays high for exactly BUS_TIMEOUT cycles before `rst_out` rises.
- R6: While `rst_out` is high, the sequence first waits for the synchronized pin to be high, then for synchronized lock. `rst_out` stays high for as long as lock is absent.
- R7: Once lock is seen, `rst_out` stays high for exactly HOLD_CYCLES further cycles. With pin high, lock present and `bus_done` high, a request gives HOLD_CYCLES+2 cycles of `rst_out`.
- R8: `cfg_strobe` is high for exactly one cycle, the last cycle in which `rst_out` is high. `cfg_value` then holds the level `cfg_pin` had in that cycle.
- R9: A pin low long enough to requalify during the lock wait or the hold count sends the sequence back to the pin-release wait. A shorter glitch leaves the count running.
- R10: Requests that arrive while `bus_mon_en` or `rst_out` is high are ignored. `cause` does not change and no second reset follows.
- R11: While `por_n` is low, `rst_out` is 1, `bus_mon_en` is 0, `cfg_strobe` is 0 and `cause` is 0. After power-on release, `rst_out` stays high for HOLD_CYCLES+3 cycles when the pin is high and lock is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_rst_n | input | 1 | Raw external reset pin, active low |
| wdog_expire | input | 1 | Watchdog timeout pulse |
| sw_rst | input | 1 | Software reset strobe |
| pll_locked | input | 1 | Raw PLL lock status |
| lol_rst_en | input | 1 | Enables loss of lock as a reset source |
| pll_mode | input | 1 | Chip is running from the PLL clock |
| bus_done | input | 1 | The current bus cycle has completed |
| cfg_pin | input | 1 | Configuration pin level |
| rst_out | output | 1 | Chip-wide reset, active high |
| bus_mon_en | output | 1 | Bus monitor enable while draining the bus cycle |
| cfg_strobe | output | 1 | Configuration capture strobe |
| cfg_value | output | 1 | Captured configuration level |
| cause | output | 4 | Sources of the most recent reset |

## Verification
The bench builds the block with QUAL_EDGES=4, HOLD_CYCLES=16 and BUS_TIMEOUT=8. With these short values, every reset sequence can be measured cycle by cycle against closed-form lengths such as HOLD_CYCLES+2. It sweeps the pin pulse width from 1 to 6 cycles to cover the qualification threshold on both sides, and lets the bus monitor run to its full timeout. It also places pin pulses at chosen offsets inside the hold count, so that both a restart and an ignored glitch fall within a single sequence.

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int QUAL_EDGES  = 4,
  parameter int HOLD_CYCLES = 512,
  parameter int BUS_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pin_rst_n,
  input  logic       wdog_expire,
  input  logic       sw_rst,
  input  logic       pll_locked,
  input  logic       lol_rst_en,
  input  logic       pll_mode,
  input  logic       bus_done,
  input  logic       cfg_pin,
  output logic       rst_out,
  output logic       bus_mon_en,
  output logic       cfg_strobe,
  output logic       cfg_value,
  output logic [3:0] cause
);
  localparam int MAXC = (HOLD_CYCLES > BUS_TIMEOUT) ? HOLD_CYCLES : BUS_TIMEOUT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int QW   = $clog2(QUAL_EDGES + 1);

  typedef enum logic [2:0] {S_RUN, S_DRAIN, S_PIN, S_LOCK, S_HOLD} state_t;

  state_t          state;
  logic [1:0]      pin_sy, lock_sy;
  logic [QW-1:0]   qcnt;
  logic [CW-1:0]   tick;
  logic [3:0]      src;
  logic            pin_low, lock_ok, pin_qual, hold_end, drain_end;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      pin_sy  <= 2'b00;
      lock_sy <= 2'b00;
    end else begin
      pin_sy  <= {pin_sy[0], pin_rst_n};
      lock_sy <= {lock_sy[0], pll_locked};
    end

  assign pin_low = ~pin_sy[1];
  assign lock_ok = lock_sy[1];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                         qcnt <= '0;
    else if (!pin_low)                  qcnt <= '0;
    else if (qcnt != QW'(QUAL_EDGES))   qcnt <= qcnt + 1'b1;

  assign pin_qual  = (qcnt == QW'(QUAL_EDGES));
  assign src       = {pll_mode & lol_rst_en & ~lock_ok, sw_rst, wdog_expire, pin_qual};
  assign hold_end  = (tick == CW'(HOLD_CYCLES - 1));
  assign drain_end = bus_done | (tick == CW'(BUS_TIMEOUT - 1));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      state     <= S_PIN;
      tick      <= '0;
      cause     <= '0;
      cfg_value <= 1'b0;
    end else begin
      case (state)
        S_RUN:
          if (|src) begin
            state <= S_DRAIN;
            cause <= src;
            tick  <= '0;
          end
        S_DRAIN:
          if (drain_end) begin
            state <= S_PIN;
            tick  <= '0;
          end else tick <= tick + 1'b1;
        S_PIN:
          if (!pin_low) state <= S_LOCK;
        S_LOCK:
          if (pin_qual) state <= S_PIN;
          else if (lock_ok) begin
            state <= S_HOLD;
            tick  <= '0;
          end
        S_HOLD:
          if (pin_qual) state <= S_PIN;
          else if (hold_end) begin
            state     <= S_RUN;
            cfg_value <= cfg_pin;
          end else tick <= tick + 1'b1;
        default: state <= S_PIN;
      endcase
    end

  assign rst_out    = (state == S_PIN) || (state == S_LOCK) || (state == S_HOLD);
  assign bus_mon_en = (state == S_DRAIN);
  assign cfg_strobe = (state == S_HOLD) && hold_end && !pin_qual;
endmodule

module rst_sequencer_chk #(
  parameter int BUS_TIMEOUT = 64
) (
  input logic       clk,
  input logic       por_n,
  input logic       rst_out,
  input logic       bus_mon_en,
  input logic       cfg_strobe,
  input logic [3:0] cause
);
  int mon_run;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)          mon_run <= 0;
    else if (bus_mon_en) mon_run <= mon_run + 1;
    else                 mon_run <= 0;

  p_mon_excl_r4: assert property (@(posedge clk) disable iff (!por_n)
    !(rst_out && bus_mon_en));

  p_rise_after_mon_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out) |-> $past(bus_mon_en));

  p_mon_bound_r5: assert property (@(posedge clk) disable iff (!por_n)
    bus_mon_en |-> (mon_run < BUS_TIMEOUT));

  p_strobe_in_reset_r8: assert property (@(posedge clk) disable iff (!por_n)
    cfg_strobe |-> rst_out);

  p_strobe_release_r8: assert property (@(posedge clk) disable iff (!por_n)
    cfg_strobe |=> !rst_out);

  p_fall_after_strobe_r8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_out) |-> $past(cfg_strobe));

  p_cause_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
    (rst_out || bus_mon_en) |=> $stable(cause));
endmodule

bind rst_sequencer rst_sequencer_chk #(.BUS_TIMEOUT(BUS_TIMEOUT)) u_chk (
  .clk(clk), .por_n(por_n), .rst_out(rst_out), .bus_mon_en(bus_mon_en),
  .cfg_strobe(cfg_strobe), .cause(cause));

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL = 4;
  localparam int HOLD = 16;
  localparam int TMO  = 8;

  logic clk = 0, por_n = 0, pin_rst_n = 1, wdog_expire = 0, sw_rst = 0;
  logic pll_locked = 1, lol_rst_en = 0, pll_mode = 0, bus_done = 1, cfg_pin = 1;
  logic rst_out, bus_mon_en, cfg_strobe, cfg_value;
  logic [3:0] cause;
  int checks = 0, errors = 0, cyc = 0;

  rst_sequencer #(.QUAL_EDGES(QUAL), .HOLD_CYCLES(HOLD), .BUS_TIMEOUT(TMO)) u_rst_sequencer (
    .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .wdog_expire(wdog_expire),
    .sw_rst(sw_rst), .pll_locked(pll_locked), .lol_rst_en(lol_rst_en),
    .pll_mode(pll_mode), .bus_done(bus_done), .cfg_pin(cfg_pin), .rst_out(rst_out),
    .bus_mon_en(bus_mon_en), .cfg_strobe(cfg_strobe), .cfg_value(cfg_value), .cause(cause));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One sequence: pulse inputs are set by the caller at a negedge; sample i is taken after edge i+1.
  task automatic run(input int pin_at, input int pin_len, input int sw_at,
                     output int mon, output int hi, output int stb);
    bit seen = 0;
    mon = 0; hi = 0; stb = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); @(negedge clk);
      if (bus_mon_en) mon++;
      if (cfg_strobe) stb++;
      if (rst_out) begin hi++; seen = 1; end
      else if (seen) break;
      wdog_expire = 0;
      sw_rst = (i == sw_at);
      pin_rst_n = !(i >= pin_at && i < pin_at + pin_len);
    end
    sw_rst = 0; pin_rst_n = 1;
  endtask

  initial begin
    int mon, hi, stb, trig;
    idle(3);
    chk("R11 rst_out in por", rst_out, 1);
    chk("R11 bus_mon_en in por", bus_mon_en, 0);
    chk("R11 cause in por", cause, 0);
    chk("R11 strobe in por", cfg_strobe, 0);
    por_n = 1;
    run(-1, 0, -1, mon, hi, stb);
    chk("R11 power-up reset length", hi, HOLD + 3);
    chk("R8 power-up strobe count", stb, 1);
    chk("R8 cfg_value high", cfg_value, 1);
    idle(4);

    // R1: pin width sweep across the qualification threshold
    for (int w = 1; w <= 6; w++) begin
      pin_rst_n = 0;
      idle(w);
      pin_rst_n = 1;
      trig = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (bus_mon_en || rst_out) trig = 1;
      end
      chk($sformatf("R1 pin width %0d", w), trig, (w >= QUAL) ? 1 : 0);
      if (trig) begin
        for (int k = 0; k < 200 && rst_out; k++) @(negedge clk);
        chk("R3 cause pin", cause, 4'b0001);
      end
      idle(4);
    end

    // R2/R3/R4/R7: watchdog with immediate bus completion
    cfg_pin = 0;
    wdog_expire = 1;
    run(-1, 0, -1, mon, hi, stb);
    chk("R4 monitor cycles with bus_done", mon, 1);
    chk("R7 reset length", hi, HOLD + 2);
    chk("R3 cause watchdog", cause, 4'b0010);
    chk("R8 cfg_value low", cfg_value, 0);
    chk("R8 strobe count", stb, 1);
    idle(4);

    // R5: bus never completes
    bus_done = 0;
    cfg_pin = 1;
    wdog_expire = 1;
    run(-1, 0, -1, mon, hi, stb);
    chk("R5 monitor timeout cycles", mon, TMO);
    chk("R5 reset length after timeout", hi, HOLD + 2);
    bus_done = 1;
    idle(4);

    // R3: two simultaneous sources
    wdog_expire = 1; sw_rst = 1;
    run(-1, 0, -1, mon, hi, stb);
    chk("R3 cause watchdog+software", cause, 4'b0110);
    chk("R2 software reset length", hi, HOLD + 2);
    idle(4);

    // R10: software request during the hold count is ignored
    wdog_expire = 1;
    run(-1, 0, 8, mon, hi, stb);
    chk("R10 length unchanged", hi, HOLD + 2);
    chk("R10 cause unchanged", cause, 4'b0010);
    idle(4);
    chk("R10 no second reset", rst_out | bus_mon_en, 0);

    // R9: short glitch during count ignored
    wdog_expire = 1;
    run(6, QUAL - 1, -1, mon, hi, stb);
    chk("R9 short glitch ignored", hi, HOLD + 2);
    idle(4);

    // R9: requalified pin restarts from pin-release wait
    wdog_expire = 1;
    run(6, 10, -1, mon, hi, stb);
    chk("R9 restart length", hi, 6 + 10 + 3 + HOLD);
    chk("R9 single strobe", stb, 1);
    idle(4);

    // R2: loss of lock disabled
    pll_mode = 1; lol_rst_en = 0;
    pll_locked = 0;
    trig = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (bus_mon_en || rst_out) trig = 1;
    end
    chk("R2 loss of lock disabled", trig, 0);
    pll_locked = 1;
    idle(4);

    // R2/R6/R7: loss of lock enabled, reset held until lock returns
    lol_rst_en = 1; cfg_pin = 0;
    pll_locked = 0;
    for (int k = 0; k < 20 && !bus_mon_en; k++) @(negedge clk);
    chk("R2 loss of lock starts reset", bus_mon_en, 1);
    idle(20);
    chk("R6 held while unlocked", rst_out, 1);
    chk("R3 cause loss of lock", cause, 4'b1000);
    pll_locked = 1;
    run(-1, 0, -1, mon, hi, stb);
    chk("R7 length after lock", hi, HOLD + 2);
    chk("R8 cfg_value after lock", cfg_value, 0);
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule